// File: doc/BRIEF.md
# Variable-Length Single-Channel DMA Engine

This block is one DMA channel. It copies a run of bytes or 16-bit words from a source address to a destination address inside a 16-bit address space. A 64-bit configuration record is presented on `cfg_rec` and taken in when `start` is pulsed while the channel is idle. That pulse also arms the channel. After that, every pulse on `trig` moves exactly one element. The element is first read from the source and then written to the destination through a request/grant memory port.

The record gives a 13-bit maximum length and a 3-bit length mode. In the two fixed modes the maximum length is the element count. In the variable modes the first element read carries a length value. The channel copies that element like any other. Once it has been read, the rest of the count is worked out from the value, a mode-selected offset and the maximum length, which acts as a cap. A reserved mode ends the job at once and raises an error flag together with `done`. `done` pulses for one cycle after the last element, and the channel then returns to idle.

Top module: `vld_dma_channel`

## Requirements
- R1: Record fields are placed as follows.
  - `cfg_rec[63:48]` is the source address and `cfg_rec[47:32]` is the destination address.
  - `cfg_rec[31:29]` is the mode and `cfg_rec[28:16]` is the 13-bit maximum length.
  - `cfg_rec[0]` set selects word elements; bits 15:1 are ignored.
  - A `start` pulse in idle loads the record, and `busy` is high in the next cycle unless the job ends at once.
- R2: Each accepted `trig` moves exactly one element: a read at the current source address is granted, then the same data is written at the current destination address. A `trig` while a move is in progress or while idle causes no access. In byte mode, bits 15:8 of the write data are zero. `mem_req` holds its address until it is granted.
- R3: After each element, both addresses advance by 1 in byte mode and by 2 in word mode.
- R4: Modes 000 and 111 move exactly the maximum length in elements.
- R5: A fixed mode with a maximum length of zero raises `done` in the cycle after `start` and makes no memory access.
- R6: Mode 001 moves the first element plus min(value+1, max length) further elements.
- R7: Mode 010 moves max(1, min(value, max length)) elements in total, counting the first element.
- R8: Mode 011 moves the first element plus min(value+2, max length) further elements. Mode 100 moves the first element plus min(value+3, max length).
- R9: The length value is bits 12:0 of the first element in word mode and bits 7:0 in byte mode.
- R10: Modes 101 and 110 raise `done` and `err` together in the cycle after `start`, with no memory access. `err` is never high without `done`.
- R11: `done` is high for exactly one cycle. That cycle is the one after the grant of the last write, and `busy` is low in it.
- R12: A `start` while the channel is busy is ignored. The running job keeps its addresses and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rec | input | 64 | Configuration record |
| start | input | 1 | Load record and arm (idle only) |
| trig | input | 1 | Move one element |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Access is a 16-bit word |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Access granted this cycle; read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Channel armed or moving an element |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved mode, high together with done |

## Verification
The assertions check the following on every cycle:
- the request stays stable while it waits for a grant;
- every granted read is followed by a write;
- the addresses step by the element size;
- the live count never exceeds the cap;
- a `start` while busy leaves the loaded record unchanged;
- `done` lasts one cycle and `err` never appears without it.

Only the bench scenarios can show the count formulas of each mode, including the cases where the cap applies. The same holds for reading the length from the correct bits of the first element, and for which addresses and data actually reach memory.

// File: rtl/vld_pkg.sv
package vld_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 13;
  localparam int REC_W  = 64;

  typedef enum logic [2:0] {
    VL_FIXED     = 3'd0,
    VL_PLUS1     = 3'd1,
    VL_INCL      = 3'd2,
    VL_PLUS2     = 3'd3,
    VL_PLUS3     = 3'd4,
    VL_RSV5      = 3'd5,
    VL_RSV6      = 3'd6,
    VL_FIXED_ALT = 3'd7
  } vl_mode_e;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_ARMED,
    CH_READ,
    CH_WRITE,
    CH_DONE
  } ch_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    vl_mode_e          mode;
    logic [LEN_W-1:0]  len;
    logic              word;
  } vl_cfg_t;

  function automatic logic mode_reserved(vl_mode_e m);
    return (m == VL_RSV5) || (m == VL_RSV6);
  endfunction

  function automatic logic mode_fixed(vl_mode_e m);
    return (m == VL_FIXED) || (m == VL_FIXED_ALT);
  endfunction

  // Elements added after the length value in the variable modes
  function automatic logic [1:0] mode_extra(vl_mode_e m);
    case (m)
      VL_PLUS1: return 2'd1;
      VL_PLUS2: return 2'd2;
      VL_PLUS3: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vld_cfg_decode.sv
module vld_cfg_decode
  import vld_pkg::*;
(
  input  logic [REC_W-1:0] rec,
  output vl_cfg_t          cfg,
  output logic             rsv,
  output logic             fixed,
  output logic             immediate
);

  logic unused_rec_bits;

  always_comb begin
    cfg.src  = rec[63:48];
    cfg.dst  = rec[47:32];
    cfg.mode = vl_mode_e'(rec[31:29]);
    cfg.len  = rec[28:16];
    cfg.word = rec[0];
  end

  assign unused_rec_bits = ^rec[15:1];
  assign rsv       = mode_reserved(cfg.mode);
  assign fixed     = mode_fixed(cfg.mode);
  // The job ends without any access: reserved mode, or fixed mode with zero length
  assign immediate = rsv || (fixed && (cfg.len == '0));

endmodule

// File: rtl/vld_len_calc.sv
module vld_len_calc
  import vld_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int DW = DATA_W
) (
  input  vl_mode_e      mode,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] first,
  input  logic          word,
  output logic [LW:0]   rest
);

  localparam int CW = LW + 1;

  logic [LW-1:0] len_val;
  logic          unused_hi;

  // Elements still to move after the first one
  function automatic logic [CW-1:0] calc_rest(vl_mode_e m, logic [LW-1:0] cap,
                                              logic [LW-1:0] v);
    logic [CW-1:0] sum;
    logic [CW-1:0] capped;
    sum    = {1'b0, v} + CW'(mode_extra(m));
    capped = (sum > {1'b0, cap}) ? {1'b0, cap} : sum;
    if (m == VL_INCL)
      return (capped == '0) ? '0 : capped - CW'(1);
    return capped;
  endfunction

  assign len_val   = word ? first[LW-1:0] : LW'(first[7:0]);
  assign unused_hi = ^first[DW-1:LW];
  assign rest      = calc_rest(mode, len, len_val);

  always_comb begin
    a_r6_rest_capped: assert (rest <= {1'b0, len});
  end

endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          step,
  input  logic          word,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);

  logic [AW-1:0] inc;

  assign inc = word ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o <= '0;
      dst_o <= '0;
    end else if (load) begin
      src_o <= src_i;
      dst_o <= dst_i;
    end else if (step) begin
      src_o <= src_o + inc;
      dst_o <= dst_o + inc;
    end
  end

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (src_o == $past(src_o) + $past(inc)) &&
                        (dst_o == $past(dst_o) + $past(inc)));

endmodule

// File: rtl/vld_dma_channel.sv
module vld_dma_channel
  import vld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REC_W-1:0]  cfg_rec,
  input  logic              start,
  input  logic              trig,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int CW = LEN_W + 1;

  ch_state_e         state;
  vl_cfg_t           cfg_d, cfg_q;
  logic              rsv_d, fixed_d, imm_d;
  logic              first_q, err_q;
  logic [CW-1:0]     cnt, cnt_nxt, rest;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] src_a, dst_a;

  // Named internal events
  logic start_acc;
  logic elem_read;
  logic elem_step;

  assign start_acc = (state == CH_IDLE) && start;
  assign elem_read = (state == CH_READ) && mem_gnt;
  assign elem_step = (state == CH_WRITE) && mem_gnt;

  vld_cfg_decode u_dec (
    .rec       (cfg_rec),
    .cfg       (cfg_d),
    .rsv       (rsv_d),
    .fixed     (fixed_d),
    .immediate (imm_d)
  );

  vld_len_calc #(.LW(LEN_W), .DW(DATA_W)) u_len (
    .mode  (cfg_q.mode),
    .len   (cfg_q.len),
    .first (data_q),
    .word  (cfg_q.word),
    .rest  (rest)
  );

  vld_addr_gen #(.AW(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_acc),
    .src_i (cfg_d.src),
    .dst_i (cfg_d.dst),
    .step  (elem_step),
    .word  (cfg_q.word),
    .src_o (src_a),
    .dst_o (dst_a)
  );

  assign cnt_nxt = first_q ? rest : cnt - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CH_IDLE;
      cfg_q   <= '0;
      cnt     <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state)
        CH_IDLE: if (start) begin
          cfg_q   <= cfg_d;
          err_q   <= rsv_d;
          first_q <= !fixed_d;
          cnt     <= fixed_d ? {1'b0, cfg_d.len} : '0;
          state   <= imm_d ? CH_DONE : CH_ARMED;
        end
        CH_ARMED: if (trig) state <= CH_READ;
        CH_READ: if (mem_gnt) begin
          data_q <= cfg_q.word ? mem_rdata : {8'h00, mem_rdata[7:0]};
          state  <= CH_WRITE;
        end
        CH_WRITE: if (mem_gnt) begin
          first_q <= 1'b0;
          cnt     <= cnt_nxt;
          state   <= (cnt_nxt == '0) ? CH_DONE : CH_ARMED;
        end
        CH_DONE: state <= CH_IDLE;
        default: state <= CH_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == CH_READ) || (state == CH_WRITE);
  assign mem_we    = (state == CH_WRITE);
  assign mem_word  = cfg_q.word;
  assign mem_addr  = (state == CH_WRITE) ? dst_a : src_a;
  assign mem_wdata = data_q;
  assign busy      = (state == CH_ARMED) || mem_req;
  assign done      = (state == CH_DONE);
  assign err       = done && err_q;

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    elem_read |=> (mem_req && mem_we));

  a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= {1'b0, cfg_q.len}));

  a_r5_immediate_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && imm_d) |=> (done && !mem_req));

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: tb/vld_dma_channel_test.sv
`timescale 1ns/1ps
module vld_dma_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_rec = '0;
  logic        start = 1'b0;
  logic        trig = 1'b0;
  logic        mem_req, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        busy, done, err;

  always #2.5 clk = ~clk;

  vld_dma_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_rec(cfg_rec), .start(start), .trig(trig),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [0:1023];
  logic [15:0] exp_rd[$];
  logic [31:0] exp_wr[$];
  int cyc = 0, done_cnt = 0, done_cyc = 0, wr_seen = 0, last_wr_cyc = 0;
  int dly = 0, gpat = 0;
  bit done_err = 0, prev_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory responder and per-cycle monitor
  always @(negedge clk) begin
    cyc++;
    mem_gnt = 1'b0;
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
      done_err = err;
      if (prev_done) chk(0, "R11", "done longer than one cycle", 2, 1);
    end
    prev_done = done;
    if (mem_req && !busy) chk(0, "R2", "request while not busy", 1, 0);
    if (mem_req) begin
      if (dly == 0) begin
        mem_gnt = 1'b1;
        dly = gpat;
        gpat = (gpat + 1) % 3;
        if (!mem_we) begin
          if (exp_rd.size() == 0) chk(0, "R2", "unexpected read", mem_addr, 0);
          else begin
            logic [15:0] ea;
            ea = exp_rd.pop_front();
            chk(mem_addr == ea, "R3", "read address", mem_addr, ea);
          end
          mem_rdata = mem_word ? {mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]}
                               : {8'hA5, mem[mem_addr[9:0]]};
        end else begin
          if (exp_wr.size() == 0) chk(0, "R2", "unexpected write", mem_addr, 0);
          else begin
            logic [31:0] ew;
            ew = exp_wr.pop_front();
            chk(mem_addr == ew[31:16], "R3", "write address", mem_addr, ew[31:16]);
            chk(mem_wdata == ew[15:0], "R2", "write data", mem_wdata, ew[15:0]);
          end
          mem[mem_addr[9:0]] = mem_wdata[7:0];
          if (mem_word) mem[mem_addr[9:0] + 10'd1] = mem_wdata[15:8];
          wr_seen++;
          last_wr_cyc = cyc;
        end
      end else dly--;
    end
  end

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run(input int mode, input int len, input int v, input bit word,
                     input int src, input int dst, input bit poke, input string tag);
    int step, n, vv;
    bit rsv, imm;
    logic [63:0] rec;
    step = word ? 2 : 1;
    for (int j = 0; j < 80; j++) mem[(src + j) & 1023] = 8'((j * 7 + 3 + src) & 255);
    mem[src & 1023] = v[7:0];
    if (word) mem[(src + 1) & 1023] = v[15:8];
    vv  = word ? (v & 16'h1FFF) : (v & 8'hFF);
    rsv = (mode == 5) || (mode == 6);
    case (mode)
      0, 7: n = len;
      1: n = 1 + imin(vv + 1, len);
      2: n = (imin(vv, len) < 1) ? 1 : imin(vv, len);
      3: n = 1 + imin(vv + 2, len);
      4: n = 1 + imin(vv + 3, len);
      default: n = 0;
    endcase
    imm = (n == 0);
    exp_rd.delete();
    exp_wr.delete();
    for (int i = 0; i < n; i++) begin
      int s;
      logic [15:0] d;
      s = (src + i * step) & 1023;
      d = word ? {mem[(s + 1) & 1023], mem[s]} : {8'h00, mem[s]};
      exp_rd.push_back(16'(src + i * step));
      exp_wr.push_back({16'(dst + i * step), d});
    end
    rec = {16'(src), 16'(dst), 3'(mode), 13'(len), 8'h00, 7'h00, word};
    done_cnt = 0;
    wr_seen = 0;
    @(negedge clk);
    cfg_rec = rec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (imm) begin
      chk(done == 1'b1, tag, "immediate done", done, 1);
      chk(err == rsv, tag, "err at immediate done", err, rsv);
    end else
      chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    for (int k = 0; k < 4000 && done_cnt == 0; k++) begin
      @(negedge clk);
      trig = (k % 3 == 0);
      if (poke && k == 7) begin
        cfg_rec = {16'h0380, 16'h03C0, 3'd0, 13'd9, 16'h0001};
        start = 1'b1;
      end else start = 1'b0;
    end
    trig = 1'b0;
    start = 1'b0;
    chk(done_cnt == 1, tag, "done seen", done_cnt, 1);
    chk(wr_seen == n, tag, "elements moved", wr_seen, n);
    chk(exp_wr.size() == 0, tag, "writes outstanding", exp_wr.size(), 0);
    chk(done_err == rsv, "R10", "err with done", done_err, rsv);
    if (n > 0) chk(done_cyc == last_wr_cyc + 1, "R11", "done after last write",
                   done_cyc, last_wr_cyc + 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R11", "idle after done", {busy, done}, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      trig = (k % 2 == 0);
    end
    trig = 1'b0;
    @(negedge clk);
    chk(wr_seen == n, "R2", "trig while idle ignored", wr_seen, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && mem_req == 0, "R1", "reset state",
        {busy, done, err, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 5, 8'h11, 0, 16'h0100, 16'h0300, 1, "R4");   // also R12 via poke
    run(7, 4, 16'h1234, 1, 16'h0100, 16'h0300, 0, "R4");
    run(0, 0, 0, 0, 16'h0100, 16'h0300, 0, "R5");
    run(7, 0, 0, 1, 16'h0100, 16'h0300, 0, "R5");
    run(1, 20, 3, 0, 16'h0110, 16'h0310, 0, "R6");
    run(1, 4, 10, 0, 16'h0110, 16'h0310, 0, "R6");
    run(2, 20, 6, 0, 16'h0120, 16'h0320, 0, "R7");
    run(2, 20, 0, 0, 16'h0120, 16'h0320, 0, "R7");
    run(2, 3, 9, 1, 16'h0120, 16'h0320, 0, "R7");
    run(3, 10, 2, 0, 16'h0130, 16'h0330, 0, "R8");
    run(4, 3, 2, 0, 16'h0130, 16'h0330, 0, "R8");
    run(1, 30, 16'hE003, 1, 16'h0140, 16'h0340, 0, "R9");
    run(4, 20, 16'h0005, 1, 16'h0140, 16'h0340, 0, "R9");
    run(5, 7, 0, 0, 16'h0100, 16'h0300, 0, "R10");
    run(6, 7, 0, 1, 16'h0100, 16'h0300, 0, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule